// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. When a request arrives it reads a directory entry from memory. Unless that entry maps a large page, it then reads a table entry. It checks the rights granted by both entries and returns either the physical address or a page fault. Each request carries the linear address, a write flag and a user-mode flag.

All memory traffic goes through a single 32-bit request/acknowledge port. Before a successful walk completes, the walker sets the accessed and dirty bits by writing the modified entries back to memory. The directory frame comes from a base-register input. Two enable inputs choose between a passthrough mode with paging off, 4 KB pages, and 4 MB pages taken straight from the directory. When a walk faults, the walker keeps the linear address in a fault-address register until the next fault.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at word address {dir_base, lin[31:22], 2'b00}. For a 4 KB walk the table entry is then read at {directory entry[31:12], lin[21:12], 2'b00}.
- R2: A successful 4 KB walk returns rsp_phys = {table entry[31:12], lin[11:0]}, with rsp_fault = 0 and rsp_vector = 0.
- R3: If the present bit (bit 0) is clear in either entry used, the walker responds with rsp_fault = 1, rsp_prot = 0, rsp_vector = 14 and rsp_phys = 0. It loads fault_addr with the linear address and writes nothing to memory.
- R4: The user bit (bit 2) and the write bit (bit 1) are ANDed across the entries used. A user-mode access needs the combined user bit set, and any write needs the combined write bit set. A violation raises vector 14 with rsp_prot = 1 and performs no memory write. A supervisor read of present entries never faults.
- R5: On success the accessed bit (bit 5) is set in every entry used. The dirty bit (bit 6) is set only in the table entry and only on a write. An entry is written back only if one of its bits changes, and no bit is ever cleared.
- R6: When large_en is 1 and the directory entry has its page-size bit (bit 7) set, the walk ends at the directory. The result is rsp_phys = {entry[31:22], lin[21:0]}, after one read and at most one write-back, which sets only the accessed bit.
- R7: When large_en is 0, the page-size bit is ignored and the walk always goes on to the table.
- R8: When paging_en is 0, the response follows acceptance by one cycle with rsp_phys equal to the linear address, and no memory access is made.
- R9: req_ready is low while a walk is in progress and during the cycle of a response. rsp_valid is a one-cycle pulse. fault_addr changes only on faults, and all outputs are zero after reset except req_ready.
- R10: A memory request holds its address, direction and data until it is acknowledged. Results are independent of the acknowledge latency, and every write carries the accessed bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Enables translation; 0 selects passthrough |
| large_en | input | 1 | Enables 4 MB pages from the directory |
| dir_base | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_prot | output | 1 | Fault caused by rights, not by absence |
| rsp_vector | output | 8 | Fault vector (14) or 0 |
| rsp_phys | output | 32 | Physical address |
| fault_addr | output | 32 | Linear address of the last fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
Random directory and table contents are mixed: absent entries, entries with the user or write right removed, large-page entries, and accessed/dirty bits already set or clear. Random addresses and access kinds are then sent through them. This separates absence faults from rights faults at each level and shows whether a write-back happens or is skipped. Running the same contents with large pages on and off tells an early-ending walk apart from a full one. Repeating the run with a slow memory acknowledge shows whether the port holds its request. Directed cases pin down exact addresses, the order of accessed and dirty updates over repeated walks, and the passthrough mode.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  localparam int P_BIT  = 0;
  localparam int RW_BIT = 1;
  localparam int US_BIT = 2;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;
  localparam int PS_BIT = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PDE_RD,
    S_PTE_RD,
    S_PDE_WR,
    S_PTE_WR
  } walk_state_t;
endpackage

// File: rtl/pt_rights.sv
`timescale 1ns/1ps
module pt_rights (
  input  logic pde_rw,
  input  logic pde_us,
  input  logic pte_rw,
  input  logic pte_us,
  input  logic use_pte,
  input  logic is_write,
  input  logic is_user,
  output logic ok
);
  logic eff_rw;
  logic eff_us;

  always_comb begin
    eff_rw = pde_rw & (pte_rw | ~use_pte);
    eff_us = pde_us & (pte_us | ~use_pte);
    ok     = (eff_us | ~is_user) & (eff_rw | ~is_write);
  end
endmodule

// File: rtl/pt_touch.sv
`timescale 1ns/1ps
module pt_touch #(
  parameter int W = 32
) (
  input  logic [W-1:0] entry,
  input  logic         set_dirty,
  output logic [W-1:0] updated,
  output logic         changed
);
  always_comb begin
    updated = entry;
    updated[pt_pkg::A_BIT] = 1'b1;
    if (set_dirty) updated[pt_pkg::D_BIT] = 1'b1;
    changed = (updated != entry);
  end
endmodule

// File: rtl/pt_xlate.sv
`timescale 1ns/1ps
module pt_xlate #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] base,
  input  logic [ADDR_W-1:0]       lin,
  input  logic [ADDR_W-OFF_W-1:0] pde_frame,
  input  logic [ADDR_W-OFF_W-1:0] pte_frame,
  output logic [ADDR_W-1:0]       pde_addr,
  output logic [ADDR_W-1:0]       pte_addr,
  output logic [ADDR_W-1:0]       phys_small,
  output logic [ADDR_W-1:0]       phys_large
);
  localparam int FRAME_W   = ADDR_W - OFF_W;
  localparam int DIR_W     = ADDR_W - IDX_W - OFF_W;
  localparam int DIR_SHIFT = OFF_W - DIR_W;
  localparam int TBL_SHIFT = OFF_W - IDX_W;
  localparam int LOFF_W    = ADDR_W - DIR_W;

  always_comb begin
    pde_addr   = {base, lin[ADDR_W-1 -: DIR_W], {DIR_SHIFT{1'b0}}};
    pte_addr   = {pde_frame, lin[OFF_W +: IDX_W], {TBL_SHIFT{1'b0}}};
    phys_small = {pte_frame, lin[OFF_W-1:0]};
    phys_large = {pde_frame[FRAME_W-1 -: DIR_W], lin[LOFF_W-1:0]};
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    paging_en,
  input  logic                    large_en,
  input  logic [ADDR_W-OFF_W-1:0] dir_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_lin,
  input  logic                    req_write,
  input  logic                    req_user,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic                    rsp_prot,
  output logic [VEC_W-1:0]        rsp_vector,
  output logic [ADDR_W-1:0]       rsp_phys,
  output logic [ADDR_W-1:0]       fault_addr,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [ADDR_W-1:0]       mem_rdata
);
  import pt_pkg::*;

  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam logic [VEC_W-1:0] VEC = VEC_W'(FAULT_VEC);

  walk_state_t         state_q;
  logic [ADDR_W-1:0]   lin_q;
  logic [FRAME_W-1:0]  base_q;
  logic                wr_q;
  logic                usr_q;
  logic                large_en_q;
  logic                large_q;
  logic [ADDR_W-1:0]   pde_q;
  logic [ADDR_W-1:0]   pte_q;

  logic                idle;
  logic [ADDR_W-1:0]   lin_sel;
  logic [FRAME_W-1:0]  base_sel;
  logic [ADDR_W-1:0]   pde_ent;
  logic [ADDR_W-1:0]   pte_ent;
  logic [ADDR_W-1:0]   pde_addr;
  logic [ADDR_W-1:0]   pte_addr;
  logic [ADDR_W-1:0]   phys_small;
  logic [ADDR_W-1:0]   phys_large;
  logic [ADDR_W-1:0]   pde_new;
  logic [ADDR_W-1:0]   pte_new;
  logic                pde_chg;
  logic                pte_chg;
  logic                rights_ok;
  logic                is_large;

  assign idle      = (state_q == S_IDLE);
  assign req_ready = idle && !rsp_valid;
  assign lin_sel   = idle ? req_lin : lin_q;
  assign base_sel  = idle ? dir_base : base_q;
  assign pde_ent   = (state_q == S_PDE_RD) ? mem_rdata : pde_q;
  assign pte_ent   = (state_q == S_PTE_RD) ? mem_rdata : pte_q;
  assign is_large  = large_en_q && pde_ent[PS_BIT];

  pt_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_xlate (
    .base       (base_sel),
    .lin        (lin_sel),
    .pde_frame  (pde_ent[ADDR_W-1:OFF_W]),
    .pte_frame  (pte_ent[ADDR_W-1:OFF_W]),
    .pde_addr   (pde_addr),
    .pte_addr   (pte_addr),
    .phys_small (phys_small),
    .phys_large (phys_large)
  );

  pt_rights u_rights (
    .pde_rw   (pde_ent[RW_BIT]),
    .pde_us   (pde_ent[US_BIT]),
    .pte_rw   (pte_ent[RW_BIT]),
    .pte_us   (pte_ent[US_BIT]),
    .use_pte  (state_q == S_PTE_RD),
    .is_write (wr_q),
    .is_user  (usr_q),
    .ok       (rights_ok)
  );

  pt_touch #(.W(ADDR_W)) u_pde_touch (
    .entry     (pde_ent),
    .set_dirty (1'b0),
    .updated   (pde_new),
    .changed   (pde_chg)
  );

  pt_touch #(.W(ADDR_W)) u_pte_touch (
    .entry     (pte_ent),
    .set_dirty (wr_q),
    .updated   (pte_new),
    .changed   (pte_chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      lin_q      <= '0;
      base_q     <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      large_en_q <= 1'b0;
      large_q    <= 1'b0;
      pde_q      <= '0;
      pte_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_prot   <= 1'b0;
      rsp_vector <= '0;
      rsp_phys   <= '0;
      fault_addr <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            lin_q      <= req_lin;
            base_q     <= dir_base;
            wr_q       <= req_write;
            usr_q      <= req_user;
            large_en_q <= large_en;
            if (!paging_en) begin
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b0;
              rsp_prot   <= 1'b0;
              rsp_vector <= '0;
              rsp_phys   <= req_lin;
            end else begin
              state_q  <= S_PDE_RD;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= pde_addr;
            end
          end
        end

        S_PDE_RD: begin
          if (mem_ack) begin
            pde_q   <= mem_rdata;
            large_q <= is_large;
            mem_req <= 1'b0;
            if (!mem_rdata[P_BIT] || (is_large && !rights_ok)) begin
              state_q    <= S_IDLE;
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b1;
              rsp_prot   <= mem_rdata[P_BIT];
              rsp_vector <= VEC;
              rsp_phys   <= '0;
              fault_addr <= lin_q;
            end else if (is_large) begin
              if (pde_chg) begin
                state_q   <= S_PDE_WR;
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= pde_addr;
                mem_wdata <= pde_new;
              end else begin
                state_q    <= S_IDLE;
                rsp_valid  <= 1'b1;
                rsp_fault  <= 1'b0;
                rsp_prot   <= 1'b0;
                rsp_vector <= '0;
                rsp_phys   <= phys_large;
              end
            end else begin
              state_q  <= S_PTE_RD;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= pte_addr;
            end
          end
        end

        S_PTE_RD: begin
          if (mem_ack) begin
            pte_q   <= mem_rdata;
            mem_req <= 1'b0;
            if (!mem_rdata[P_BIT] || !rights_ok) begin
              state_q    <= S_IDLE;
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b1;
              rsp_prot   <= mem_rdata[P_BIT];
              rsp_vector <= VEC;
              rsp_phys   <= '0;
              fault_addr <= lin_q;
            end else if (pde_chg) begin
              state_q   <= S_PDE_WR;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= pde_addr;
              mem_wdata <= pde_new;
            end else if (pte_chg) begin
              state_q   <= S_PTE_WR;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= pte_addr;
              mem_wdata <= pte_new;
            end else begin
              state_q    <= S_IDLE;
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b0;
              rsp_prot   <= 1'b0;
              rsp_vector <= '0;
              rsp_phys   <= phys_small;
            end
          end
        end

        S_PDE_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (!large_q && pte_chg) begin
              state_q   <= S_PTE_WR;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= pte_addr;
              mem_wdata <= pte_new;
            end else begin
              state_q    <= S_IDLE;
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b0;
              rsp_prot   <= 1'b0;
              rsp_vector <= '0;
              rsp_phys   <= large_q ? phys_large : phys_small;
            end
          end
        end

        S_PTE_WR: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            state_q    <= S_IDLE;
            rsp_valid  <= 1'b1;
            rsp_fault  <= 1'b0;
            rsp_prot   <= 1'b0;
            rsp_vector <= '0;
            rsp_phys   <= phys_small;
          end
        end

        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              paging_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_lin,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [VEC_W-1:0]  rsp_vector,
  input logic [ADDR_W-1:0] rsp_phys,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              mem_ack
);
  assert_fault_vector_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_vector == VEC_W'(FAULT_VEC));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !paging_en |=> rsp_valid && !rsp_fault && rsp_phys == $past(req_lin));

  assert_passthrough_nomem_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !paging_en |=> !mem_req);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_fault_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> $stable(fault_addr));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_write_accessed_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[pt_pkg::A_BIT]);
endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .paging_en  (paging_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_lin    (req_lin),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_vector (rsp_vector),
  .rsp_phys   (rsp_phys),
  .fault_addr (fault_addr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        paging_en, large_en;
  logic [19:0] dir_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_lin;
  logic        rsp_valid, rsp_fault, rsp_prot;
  logic [7:0]  rsp_vector;
  logic [31:0] rsp_phys, fault_addr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:4095];
  int wr_cnt = 0;
  int rd_cnt = 0;
  int ack_lat = 0;
  int dly = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_fa = 32'h0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .paging_en(paging_en), .large_en(large_en),
    .dir_base(dir_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_prot(rsp_prot),
    .rsp_vector(rsp_vector), .rsp_phys(rsp_phys), .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with programmable acknowledge latency
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      dly     <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (dly < ack_lat) dly <= dly + 1;
        else begin
          dly       <= 0;
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[13:2]];
          if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
          end else rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected walk outcome, computed from the requirements
  task automatic model(input logic [31:0] lin, input logic wr, input logic usr,
                       output logic flt, output logic prot, output logic [31:0] phys,
                       output int nrd, output int nwr, output int pidx, output logic [31:0] pexp,
                       output int tidx, output logic [31:0] texp);
    logic [31:0] pde, pte;
    logic rw, us;
    flt = 0; prot = 0; phys = 0; nrd = 0; nwr = 0; tidx = -1; texp = 0;
    pidx = int'(lin[31:22]);
    pde  = mem[pidx];
    pexp = pde;
    if (!paging_en) begin
      phys = lin; pidx = -1;
      return;
    end
    nrd = 1;
    if (!pde[0]) begin flt = 1; return; end
    if (large_en && pde[7]) begin
      if ((usr && !pde[2]) || (wr && !pde[1])) begin flt = 1; prot = 1; return; end
      pexp = pde | 32'h20;
      nwr  = pde[5] ? 0 : 1;
      phys = {pde[31:22], lin[21:0]};
      return;
    end
    tidx = int'({pde[13:12], lin[21:12]});
    pte  = mem[tidx];
    texp = pte;
    nrd  = 2;
    if (!pte[0]) begin flt = 1; return; end
    rw = pde[1] & pte[1];
    us = pde[2] & pte[2];
    if ((usr && !us) || (wr && !rw)) begin flt = 1; prot = 1; return; end
    pexp = pde | 32'h20;
    texp = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    nwr  = int'(pexp != pde) + int'(texp != pte);
    phys = {pte[31:12], lin[11:0]};
  endtask

  task automatic walk(input logic [31:0] lin, input logic wr, input logic usr, input string tag);
    logic flt, prot;
    logic [31:0] phys, pexp, texp;
    int nrd, nwr, pidx, tidx, w0, r0, n;
    model(lin, wr, usr, flt, prot, phys, nrd, nwr, pidx, pexp, tidx, texp);
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 0;
    if (paging_en && !rsp_valid) chk("R9", "ready low while walking", {31'b0, req_ready}, 32'h0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      n_chk++; n_fail++;
      $display("FAIL %s no response actual=0 expected=1", tag);
      return;
    end
    if (flt) exp_fa = lin;
    chk(tag, "fault", {31'b0, rsp_fault}, {31'b0, flt});
    chk(tag, "prot", {31'b0, rsp_prot}, {31'b0, prot});
    chk(tag, "vector", {24'b0, rsp_vector}, flt ? 32'd14 : 32'd0);
    chk(tag, "phys", rsp_phys, phys);
    chk(tag, "fault_addr R9", fault_addr, exp_fa);
    chk(tag, "reads R1", rd_cnt - r0, nrd);
    chk(tag, "writes R5", wr_cnt - w0, nwr);
    if (pidx >= 0) chk(tag, "dir entry R5", mem[pidx], pexp);
    if (tidx >= 0) chk(tag, "table entry R5", mem[tidx], texp);
    @(negedge clk);
    chk("R9", "rsp pulse", {31'b0, rsp_valid}, 32'h0);
  endtask

  function automatic logic [31:0] rflags(input logic present);
    logic [31:0] f;
    f = {24'h0, $urandom} & 32'h60;
    f[0] = present;
    f[1] = ($urandom % 4) != 0;
    f[2] = ($urandom % 4) != 0;
    return f;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] e;
      logic [1:0] t;
      t = 2'(1 + ($urandom % 3));
      e = {$urandom} & 32'hFFFFC000;
      e[13:12] = t;
      e = e | rflags(($urandom % 8) != 0);
      e[7] = ($urandom % 4) == 0;
      mem[i] = e;
    end
    for (int i = 1024; i < 4096; i++)
      mem[i] = ({$urandom} & 32'hFFFFF000) | rflags(($urandom % 8) != 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    rst = 1; paging_en = 1; large_en = 0; dir_base = 20'h0;
    req_valid = 0; req_lin = 0; req_write = 0; req_user = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9", "reset ready", {31'b0, req_ready}, 32'h1);
    chk("R9", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R9", "reset mem_req", {31'b0, mem_req}, 32'h0);
    chk("R9", "reset fault_addr", fault_addr, 32'h0);

    // R1 R2 R5: basic 4 KB walk then dirty update then no-op
    mem[5]        = 32'h0000_1007;
    mem[1024 + 3] = 32'hABCD_E007;
    walk({10'd5, 10'd3, 12'h123}, 1'b0, 1'b1, "R2");
    chk("R2", "directed phys", rsp_phys, 32'hABCD_E123);
    chk("R1", "dir entry accessed", mem[5], 32'h0000_1027);
    walk({10'd5, 10'd3, 12'h456}, 1'b1, 1'b0, "R5");
    chk("R5", "dirty set", mem[1024 + 3], 32'hABCD_E067);
    walk({10'd5, 10'd3, 12'h456}, 1'b1, 1'b0, "R5");

    // R3: not present at each level
    mem[6] = 32'h0000_2006;
    walk({10'd6, 10'd0, 12'h0}, 1'b0, 1'b0, "R3");
    mem[7] = 32'h0000_2007;
    mem[2048 + 9] = 32'h1234_5006;
    walk({10'd7, 10'd9, 12'h10}, 1'b1, 1'b0, "R3");
    chk("R3", "no dir update", mem[7], 32'h0000_2007);

    // R4: rights at table and directory level
    mem[8] = 32'h0000_3007;
    mem[3072 + 1] = 32'h5555_5003;
    walk({10'd8, 10'd1, 12'h0}, 1'b0, 1'b1, "R4");
    walk({10'd8, 10'd1, 12'h0}, 1'b1, 1'b0, "R4");
    mem[9] = 32'h0000_1005;
    mem[1024 + 10] = 32'h7777_7007;
    walk({10'd9, 10'd10, 12'h0}, 1'b1, 1'b0, "R4");
    walk({10'd9, 10'd10, 12'h0}, 1'b0, 1'b1, "R4");

    // R6 R7: large page on and off
    large_en = 1;
    mem[10] = {10'h2AB, 10'h001, 12'h087};
    mem[1024 + 5] = 32'h9999_9007;
    walk({10'd10, 10'd5, 12'hABC}, 1'b1, 1'b1, "R6");
    chk("R6", "large phys", rsp_phys, {10'h2AB, 10'd5, 12'hABC});
    large_en = 0;
    walk({10'd10, 10'd5, 12'hABC}, 1'b0, 1'b0, "R7");
    chk("R7", "ps ignored phys", rsp_phys, 32'h9999_9ABC);

    // R8: passthrough
    paging_en = 0;
    walk(32'hDEAD_BEEF, 1'b1, 1'b1, "R8");
    paging_en = 1;

    // random walks, both page modes and two acknowledge latencies
    for (int round = 0; round < 4; round++) begin
      fill_random();
      large_en = round[0];
      ack_lat  = round[1] ? 3 : 0;
      for (int k = 0; k < 150; k++) begin
        string tg;
        paging_en = ($urandom % 16) != 0;
        tg = ack_lat != 0 ? "R10" : (large_en ? "R6" : "R4");
        walk($urandom, 1'($urandom), 1'($urandom), tg);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule